// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps the wall-clock date and time for a chip. It divides a 32768 Hz reference clock down to a one-second strobe. On each strobe it advances seconds, minutes, hours, weekday, day of month, month and a three-digit year. The day count follows month lengths and the Gregorian leap rule. All calendar and alarm fields are read and written as packed BCD through a simple register port. The read port is combinational and the write port is a single-cycle strobe. Time is held internally in binary.

An alarm unit compares the freshly advanced time against programmed BCD values once per second. Each of the six comparable fields has its own enable bit, and one global bit gates the whole unit. A match on any enabled field sets a sticky pending flag and drives the interrupt line. Software clears the flag by writing 1 to it.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the clock is stopped, all alarm registers and the pending flag are 0, `alarm_irq` is low, and the calendar reads 00:00:00, weekday 0, day 0x01, month 0x01, year 0x100.
- R2: Writing control bit 0 = 1 starts the divider from zero. The first calendar advance happens on the clock edge DIV cycles after the enabling write, and further advances follow every DIV cycles. Writing bit 0 = 0 stops the advance.
- R3: On each advance, seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and start a new day. On a new day the weekday goes up by one and wraps from 6 to 0.
- R4: Month lengths are 31/28/31/30/31/30/31/31/30/31/30/31. February has 29 days when (year + 1900) is divisible by 4, except century years not divisible by 400. A day beyond the month length becomes 1 and advances the month. December rolls into January and increments the year.
- R5: The month reads and writes as BCD 0x01 to 0x12. The year register holds the tens and units digits in bits 7:0 and the hundreds digit in bits 11:8. Every other calendar field is two BCD digits in bits 7:0.
- R6: Writes to any calendar field are ignored while control bit 0 is 0.
- R7: Alarm value writes keep only their low bits: 7 for seconds and minutes, 6 for hours and day, 5 for month and 12 for year.
- R8: Alarm-control bits 0 to 5 enable comparison of seconds, minutes, hours, day, month and year in that order. Bit 6 enables the alarm as a whole. The alarm fires when any one enabled field matches.
- R9: The comparison uses the time just produced by each advance. A match sets pending bit 1 and raises `alarm_irq` on that same edge.
- R10: The pending flag stays set until a write to the pending register with bit 1 = 1 clears it. Writing only bit 0 leaves it set.
- R11: The month alarm compares against the zero-based month, January = 0x00, without the +1 read offset.
- R12: Register addresses: 0 control, 1 alarm control, 2 pending, 3 alarm seconds, 4 alarm minutes, 5 alarm hours, 6 alarm day, 7 alarm month, 8 alarm year, 9 seconds, 10 minutes, 11 hours, 12 weekday, 13 day, 14 month, 15 year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz reference clock (DIV cycles per second) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt, high while pending |

## Verification
A wrong carry or month-length decision only shows at the ports on the single advance that crosses the boundary. It then stays visible in every later read of the affected field. For that reason, each rollover check preloads the time one second before the boundary and reads the fields inside that second's window. An alarm that is compared against stale time, or against the one-based month, changes `alarm_irq` exactly one second early or late, or not at all. The bench therefore checks the interrupt at both the second before the match and the second of the match.

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
  parameter int DIV = 32768
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        alarm_irq
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [3:0] A_CTRL = 4'd0, A_ACTL = 4'd1, A_PEND = 4'd2,
    A_ASEC = 4'd3, A_AMIN = 4'd4, A_AHR = 4'd5, A_ADAY = 4'd6, A_AMON = 4'd7,
    A_AYR = 4'd8, A_SEC = 4'd9, A_MIN = 4'd10, A_HR = 4'd11, A_WDAY = 4'd12,
    A_MDAY = 4'd13, A_MON = 4'd14, A_YR = 4'd15;

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return {3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]};
  endfunction

  function automatic logic [11:0] yr2bcd(input logic [10:0] y);
    logic [10:0] r;
    r = y % 11'd1000;
    return {4'(r / 11'd100), bin2bcd(7'(r % 11'd100))};
  endfunction

  logic          run_q, pend;
  logic [6:0]    actl, asec, amin;
  logic [5:0]    ahr, aday;
  logic [4:0]    amon;
  logic [11:0]   ayr;
  logic [6:0]    sec_q, min_q, hr_q, wd_q, md_q, mo_q;
  logic [10:0]   yr_q;
  logic [CW-1:0] cnt;

  logic          strobe, leap, hit;
  logic [11:0]   full_yr;
  logic [6:0]    dim;
  logic [6:0]    s_n, m_n, h_n, wd_n, d_n, mo_n;
  logic [10:0]   y_n;

  assign strobe  = run_q && (cnt == CW'(DIV - 1));
  assign full_yr = {1'b0, yr_q} + 12'd1900;
  assign leap    = (full_yr % 12'd4 == 12'd0) &&
                   ((full_yr % 12'd100 != 12'd0) || (full_yr % 12'd400 == 12'd0));

  always_comb begin
    case (mo_q)
      7'd1:                      dim = leap ? 7'd29 : 7'd28;
      7'd3, 7'd5, 7'd8, 7'd10:   dim = 7'd30;
      default:                   dim = 7'd31;
    endcase
  end

  always_comb begin
    s_n = sec_q + 7'd1; m_n = min_q; h_n = hr_q; wd_n = wd_q;
    d_n = md_q; mo_n = mo_q; y_n = yr_q;
    if (s_n >= 7'd60) begin
      s_n = 7'd0; m_n = min_q + 7'd1;
      if (m_n >= 7'd60) begin
        m_n = 7'd0; h_n = hr_q + 7'd1;
        if (h_n >= 7'd24) begin
          h_n = 7'd0;
          wd_n = (wd_q + 7'd1 >= 7'd7) ? 7'd0 : wd_q + 7'd1;
          d_n = md_q + 7'd1;
          if (d_n > dim) begin
            d_n = 7'd1; mo_n = mo_q + 7'd1;
            if (mo_n >= 7'd12) begin
              mo_n = 7'd0; y_n = yr_q + 11'd1;
            end
          end
        end
      end
    end
  end

  assign hit = actl[6] && (
      (actl[0] && bin2bcd(s_n)  == {1'b0, asec}) ||
      (actl[1] && bin2bcd(m_n)  == {1'b0, amin}) ||
      (actl[2] && bin2bcd(h_n)  == {2'b0, ahr})  ||
      (actl[3] && bin2bcd(d_n)  == {2'b0, aday}) ||
      (actl[4] && bin2bcd(mo_n) == {3'b0, amon}) ||
      (actl[5] && yr2bcd(y_n)   == ayr));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; pend <= 1'b0; actl <= '0;
      asec <= '0; amin <= '0; ahr <= '0; aday <= '0; amon <= '0; ayr <= '0;
      sec_q <= '0; min_q <= '0; hr_q <= '0; wd_q <= '0;
      md_q <= 7'd1; mo_q <= '0; yr_q <= 11'd100;
      cnt <= '0;
    end else begin
      cnt <= (!run_q || strobe) ? '0 : cnt + 1'b1;
      if (strobe) begin
        sec_q <= s_n; min_q <= m_n; hr_q <= h_n; wd_q <= wd_n;
        md_q <= d_n; mo_q <= mo_n; yr_q <= y_n;
      end
      if (strobe && hit)
        pend <= 1'b1;
      else if (wr_en && addr == A_PEND && wdata[1])
        pend <= 1'b0;
      if (wr_en) begin
        case (addr)
          A_CTRL: run_q <= wdata[0];
          A_ACTL: actl  <= wdata[6:0];
          A_ASEC: asec  <= wdata[6:0];
          A_AMIN: amin  <= wdata[6:0];
          A_AHR:  ahr   <= wdata[5:0];
          A_ADAY: aday  <= wdata[5:0];
          A_AMON: amon  <= wdata[4:0];
          A_AYR:  ayr   <= wdata[11:0];
          A_SEC:  if (run_q) sec_q <= bcd2bin(wdata[7:0]);
          A_MIN:  if (run_q) min_q <= bcd2bin(wdata[7:0]);
          A_HR:   if (run_q) hr_q  <= bcd2bin(wdata[7:0]);
          A_WDAY: if (run_q) wd_q  <= bcd2bin(wdata[7:0]);
          A_MDAY: if (run_q) md_q  <= bcd2bin(wdata[7:0]);
          A_MON:  if (run_q) mo_q  <= bcd2bin(wdata[7:0]) - 7'd1;
          A_YR:   if (run_q) yr_q  <= {7'b0, wdata[11:8]} * 11'd100 +
                                      {4'b0, bcd2bin(wdata[7:0])};
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {15'b0, run_q};
      A_ACTL:  rdata = {9'b0, actl};
      A_PEND:  rdata = {14'b0, pend, 1'b0};
      A_ASEC:  rdata = {9'b0, asec};
      A_AMIN:  rdata = {9'b0, amin};
      A_AHR:   rdata = {10'b0, ahr};
      A_ADAY:  rdata = {10'b0, aday};
      A_AMON:  rdata = {11'b0, amon};
      A_AYR:   rdata = {4'b0, ayr};
      A_SEC:   rdata = {8'b0, bin2bcd(sec_q)};
      A_MIN:   rdata = {8'b0, bin2bcd(min_q)};
      A_HR:    rdata = {8'b0, bin2bcd(hr_q)};
      A_WDAY:  rdata = {8'b0, bin2bcd(wd_q)};
      A_MDAY:  rdata = {8'b0, bin2bcd(md_q)};
      A_MON:   rdata = {8'b0, bin2bcd(mo_q + 7'd1)};
      default: rdata = {4'b0, yr2bcd(yr_q)};
    endcase
  end

  assign alarm_irq = pend;

  // R10: pending flag holds unless explicitly cleared
  assert_alarm_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (pend && !(wr_en && addr == A_PEND && wdata[1])) |=> pend);

  // R9: the flag only rises on the edge of a seconds advance
  assert_alarm_on_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(strobe));

  // R6: a stopped clock keeps every calendar field
  assert_frozen_when_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> ($stable(sec_q) && $stable(md_q) && $stable(yr_q)));

  // R2: seconds change only on an advance or a write
  assert_sec_only_on_event_R2: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !(wr_en && addr == A_SEC)) |=> $stable(sec_q));
endmodule

// File: tb/bcd_calendar_clock_bench.sv
module bcd_calendar_clock_bench;
  localparam int DIV = 64;
  localparam logic [3:0] CTRL = 4'd0, ACTL = 4'd1, PEND = 4'd2, ASEC = 4'd3,
    AMIN = 4'd4, AHR = 4'd5, ADAY = 4'd6, AMON = 4'd7, AYR = 4'd8, SEC = 4'd9,
    MIN = 4'd10, HR = 4'd11, WDAY = 4'd12, MDAY = 4'd13, MON = 4'd14, YR = 4'd15;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [15:0] wdata = 16'd0, rdata;
  logic alarm_irq;

  bcd_calendar_clock #(.DIV(DIV)) u_bcd_calendar_clock (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .alarm_irq(alarm_irq));

  always #10 clk = ~clk;

  typedef struct { bit is_irq; logic [15:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0, cyc = 0, t0 = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(negedge clk); #2;
      while (q.size() != 0) begin
        item_t it;
        logic [15:0] got;
        it = q.pop_front();
        got = it.is_irq ? {15'b0, alarm_irq} : rdata;
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
    @(negedge clk); addr = a;
    q.push_back('{1'b0, e, tag}); #3;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    q.push_back('{1'b1, {15'b0, e}, tag}); #3;
  endtask

  task automatic set_cal(input logic [15:0] y, mo, d, wd, h, m, s);
    wr(CTRL, 16'h0); wr(CTRL, 16'h1); t0 = cyc;
    wr(YR, y); wr(MON, mo); wr(MDAY, d); wr(WDAY, wd);
    wr(HR, h); wr(MIN, m); wr(SEC, s); wr(PEND, 16'h2);
  endtask

  task automatic wait_sec(input int n);
    while (cyc < t0 + n * DIV) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(CTRL, 16'h0000, "R1 control");
    rd(PEND, 16'h0000, "R1 pending");
    rd(SEC, 16'h0000, "R1 seconds");
    rd(MDAY, 16'h0001, "R1 day");
    rd(MON, 16'h0001, "R1 month");
    rd(YR, 16'h0100, "R1 year");
    chk_irq(1'b0, "R1 irq");
    // R2 running
    wr(CTRL, 16'h0); wr(CTRL, 16'h1); t0 = cyc;
    wait_sec(1); rd(SEC, 16'h0001, "R2 first advance");
    wait_sec(3); rd(SEC, 16'h0003, "R2 third advance");
    // R6 stopped, calendar write ignored
    wr(CTRL, 16'h0); wr(SEC, 16'h0045);
    repeat (2 * DIV + 2) @(negedge clk);
    rd(SEC, 16'h0003, "R6 write ignored and R2 stopped");
    // R3 R4 R5 full rollover
    set_cal(16'h0199, 16'h0012, 16'h0031, 16'h0006, 16'h0023, 16'h0059, 16'h0059);
    wait_sec(1);
    rd(SEC, 16'h0000, "R3 sec wrap"); rd(MIN, 16'h0000, "R3 min wrap");
    rd(HR, 16'h0000, "R3 hour wrap"); rd(WDAY, 16'h0000, "R3 weekday wrap");
    rd(MDAY, 16'h0001, "R4 day reset"); rd(MON, 16'h0001, "R5 month to 01");
    rd(YR, 16'h0200, "R5 year hundreds carry");
    set_cal(16'h0123, 16'h0007, 16'h0010, 16'h0002, 16'h0009, 16'h0059, 16'h0059);
    wait_sec(1);
    rd(HR, 16'h0010, "R3 hour carry"); rd(MDAY, 16'h0010, "R3 no day change");
    // R4 leap rules
    set_cal(16'h0100, 16'h0002, 16'h0028, 16'h0000, 16'h0023, 16'h0059, 16'h0059);
    wait_sec(1);
    rd(MDAY, 16'h0029, "R4 2000 leap"); rd(MON, 16'h0002, "R4 2000 still Feb");
    set_cal(16'h0000, 16'h0002, 16'h0028, 16'h0000, 16'h0023, 16'h0059, 16'h0059);
    wait_sec(1);
    rd(MDAY, 16'h0001, "R4 1900 not leap"); rd(MON, 16'h0003, "R4 1900 March");
    set_cal(16'h0104, 16'h0002, 16'h0029, 16'h0000, 16'h0023, 16'h0059, 16'h0059);
    wait_sec(1);
    rd(MDAY, 16'h0001, "R4 2004 end Feb"); rd(MON, 16'h0003, "R4 2004 March");
    set_cal(16'h0123, 16'h0004, 16'h0030, 16'h0000, 16'h0023, 16'h0059, 16'h0059);
    wait_sec(1);
    rd(MDAY, 16'h0001, "R4 April 30 days"); rd(MON, 16'h0005, "R4 May");
    // R7 masks
    wr(ASEC, 16'hFFFF); rd(ASEC, 16'h007F, "R7 alarm sec mask");
    wr(AMIN, 16'hFFFF); rd(AMIN, 16'h007F, "R7 alarm min mask");
    wr(AHR, 16'hFFFF);  rd(AHR, 16'h003F, "R7 alarm hour mask");
    wr(ADAY, 16'hFFFF); rd(ADAY, 16'h003F, "R7 alarm day mask");
    wr(AMON, 16'hFFFF); rd(AMON, 16'h001F, "R7 alarm month mask");
    wr(AYR, 16'hFFFF);  rd(AYR, 16'h0FFF, "R7 alarm year mask");
    // R8 R9 any-match, R10 sticky and clear
    wr(ASEC, 16'h0005); wr(AMIN, 16'h0030); wr(ACTL, 16'h0043);
    set_cal(16'h0120, 16'h0006, 16'h0015, 16'h0003, 16'h0010, 16'h0020, 16'h0003);
    wait_sec(1);
    chk_irq(1'b0, "R9 no match yet"); rd(SEC, 16'h0004, "R9 sec 04");
    wait_sec(2);
    chk_irq(1'b1, "R8 seconds alone matches"); rd(PEND, 16'h0002, "R9 pending bit1");
    wait_sec(3);
    chk_irq(1'b1, "R10 sticky"); rd(SEC, 16'h0006, "R10 sec 06");
    wr(PEND, 16'h0001); chk_irq(1'b1, "R10 bit0 no clear");
    wr(PEND, 16'h0002); chk_irq(1'b0, "R10 cleared");
    rd(PEND, 16'h0000, "R10 pending zero");
    wait_sec(4); chk_irq(1'b0, "R10 stays clear");
    // R8 global enable off
    wr(ACTL, 16'h0001);
    set_cal(16'h0120, 16'h0006, 16'h0015, 16'h0003, 16'h0010, 16'h0020, 16'h0004);
    wait_sec(1); chk_irq(1'b0, "R8 global off");
    // R9 day alarm after rollover
    wr(ADAY, 16'h0016); wr(ACTL, 16'h0048);
    set_cal(16'h0123, 16'h0006, 16'h0015, 16'h0002, 16'h0023, 16'h0059, 16'h0059);
    wait_sec(1); chk_irq(1'b1, "R9 day match after advance");
    // R11 zero-based month
    wr(AMON, 16'h0003); wr(ACTL, 16'h0050);
    set_cal(16'h0123, 16'h0003, 16'h0010, 16'h0001, 16'h0010, 16'h0000, 16'h0000);
    wait_sec(1); chk_irq(1'b0, "R11 one-based value no match");
    wr(AMON, 16'h0002);
    wait_sec(2); chk_irq(1'b1, "R11 zero-based match"); rd(MON, 16'h0003, "R11 month reads 03");
    // R8 year field
    wr(AYR, 16'h0123); wr(ACTL, 16'h0060);
    set_cal(16'h0123, 16'h0008, 16'h0010, 16'h0001, 16'h0010, 16'h0000, 16'h0000);
    wait_sec(1); chk_irq(1'b1, "R8 year match");
    // R12 map readback
    rd(ACTL, 16'h0060, "R12 alarm control address");
    rd(CTRL, 16'h0001, "R12 control address");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule